// File: doc/BRIEF.md
# I2C SCL Timing Parameter Generator

This block turns a requested bus speed (in kHz) and a bus mode into the divider settings an I2C master needs. It derives a prescaler, which divides the fixed functional clock down to an internal tick clock. It also derives the number of internal ticks that SCL spends low and high. It then drives a continuous SCL waveform from those settings until it is reconfigured.

A one-cycle `start` latches the mode and speed. An iterative divider computes the base count over a fixed number of cycles. The block then publishes the prescaler and the two period words, or raises an error flag.

Standard mode splits the period evenly. Fast mode gives roughly two thirds of the period to the low phase. High-speed mode holds two phase counts in each period word: the upper byte holds the high-speed phase and the lower byte holds the slower preamble phase. A select input picks which pair drives SCL.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset `busy`, `cfg_ok` and `cfg_err` are 0, the prescaler and both period outputs are 0, and `scl_o` is 1.
- R2: A `start` while `busy` is 0 raises `busy` on the next cycle. `busy` stays high until the result is published. A `start` while `busy` is 1 is ignored, and the published result matches the first request.
- R3: The prescaler output equals functional clock / internal clock − 1, with the internal clock chosen per mode (defaults 4000, 9600 and 19200 kHz against 96000 kHz, giving 23, 9 and 4). A prescaler of zero or less is an error.
- R4: Mode code 0 (standard): with q = 4000 / (2·speed), the low count is q − 7 and the high count is q − 5.
- R5: Mode code 1 (fast): with q = 9600 / speed and t = q / 3 (both rounded down), the low count is q − t − 7 and the high count is t − 5.
- R6: Mode code 2 (high speed): the upper byte of each period output holds the high-speed phase count. That count is 19200 / (2·speed) less 7 for the low word and less 5 for the high word. The lower byte holds the preamble count, 19200 / 800 less 7 (low) or less 5 (high).
- R7: In high-speed mode, a phase count below 0 or above 255 is an error.
- R8: In standard or fast mode, a low or high count of zero or below, or one that does not fit the period width, is an error.
- R9: Speed 0 or mode code 3 is an error. On any error `cfg_err` is 1, `cfg_ok` is 0, and the prescaler and period outputs read 0. `cfg_ok` and `cfg_err` are never both 1.
- R10: While `cfg_ok` is 1, SCL repeats a low phase of (low+1)·(prescaler+1) clock cycles and a high phase of (high+1)·(prescaler+1) cycles, and changes level only after an internal tick.
- R11: In high-speed mode, `hs_phase` = 1 drives SCL from the upper bytes and `hs_phase` = 0 from the lower bytes.
- R12: While `cfg_ok` is 0 (busy, errored or never configured), `scl_o` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new computation |
| mode | input | 2 | 0 standard, 1 fast, 2 high speed, 3 invalid |
| hs_phase | input | 1 | In high-speed mode, selects the phase pair that drives SCL |
| speed_khz | input | SPD_W | Requested bus speed in kHz |
| busy | output | 1 | Computation in progress |
| cfg_ok | output | 1 | Valid configuration published, SCL running |
| cfg_err | output | 1 | Last request was rejected |
| psc_o | output | PSC_W | Prescaler value |
| scl_lo_o | output | CNT_W | Low-period word |
| scl_hi_o | output | CNT_W | High-period word |
| scl_o | output | 1 | Generated SCL level |

## Verification
Each mode is swept over a wide range of speeds, stepping so that the rounded-down quotients hit both exact and inexact divisions. This separates correct flooring and the two-thirds split from off-by-one trims. Speeds sit on each side of every range limit: the last standard and fast speeds before a count reaches zero, and the high-speed speeds where a phase count crosses 0 or 255. These tell a correct range check from a check that is off by one or has the wrong sign. Waveform lengths are measured in all three modes and for both high-speed phase selections. Because each mode gives a different prescaler, these measurements distinguish prescaler errors from count errors. Speed zero, mode 3 and a start issued while busy show that the block rejects bad requests and ignores a start it cannot take.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  localparam logic [1:0] MODE_STD  = 2'd0;
  localparam logic [1:0] MODE_FAST = 2'd1;
  localparam logic [1:0] MODE_HS   = 2'd2;

  // base count less a trim, used by standard and high-speed phases
  function automatic int trim_sub(input int base, input int trim);
    return base - trim;
  endfunction

  // fast mode: low part takes what remains after the third
  function automatic int fast_low(input int total, input int trim);
    return total - (total / 3) - trim;
  endfunction

  function automatic int fast_high(input int total, input int trim);
    return (total / 3) - trim;
  endfunction

  // strictly positive and representable in w bits
  function automatic logic fits_pos(input int v, input int w);
    return (v > 0) && (v < (1 << w));
  endfunction

  // zero allowed, representable in w bits
  function automatic logic fits_nonneg(input int v, input int w);
    return (v >= 0) && (v < (1 << w));
  endfunction

endpackage

// File: rtl/scl_div.sv
module scl_div #(
  parameter int QW = 16,
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [QW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [QW-1:0] quotient,
  output logic          done
);
  localparam int CW = $clog2(QW + 1);

  logic [DW-1:0] rem_q;
  logic [DW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   shifted;
  logic          fits;

  assign shifted = {rem_q, quotient[QW-1]};
  assign fits    = shifted >= {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      dvs_q    <= '0;
      quotient <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
    end else if (go) begin
      rem_q    <= '0;
      dvs_q    <= divisor;
      quotient <= dividend;
      cnt_q    <= CW'(QW);
      done     <= 1'b0;
    end else if (cnt_q != '0) begin
      if (fits) begin
        rem_q    <= DW'(shifted - {1'b0, dvs_q});
        quotient <= {quotient[QW-2:0], 1'b1};
      end else begin
        rem_q    <= shifted[DW-1:0];
        quotient <= {quotient[QW-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      done  <= (cnt_q == CW'(1));
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/scl_wave.sv
module scl_wave #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [CNT_W-1:0] hi_cnt,
  output logic             scl,
  output logic             tick_o,
  output logic             flip_o
);
  logic [PSC_W-1:0] pre_q;
  logic [CNT_W-1:0] ph_q;
  logic             high_q;

  assign tick_o = en && (pre_q == psc);
  assign flip_o = tick_o && (ph_q == (high_q ? hi_cnt : lo_cnt));
  assign scl    = !en || high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ph_q   <= '0;
      high_q <= 1'b0;
    end else if (!en) begin
      pre_q  <= '0;
      ph_q   <= '0;
      high_q <= 1'b0;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (flip_o) begin
        high_q <= !high_q;
        ph_q   <= '0;
      end else if (tick_o) begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int FCLK_KHZ    = 96000,
  parameter int STD_INT_KHZ = 4000,
  parameter int FST_INT_KHZ = 9600,
  parameter int HS_INT_KHZ  = 19200,
  parameter int PRE_KHZ     = 400,
  parameter int TRIM_LO     = 7,
  parameter int TRIM_HI     = 5,
  parameter int HS1_TRIM_LO = 7,
  parameter int HS1_TRIM_HI = 5,
  parameter int HS2_TRIM_LO = 7,
  parameter int HS2_TRIM_HI = 5,
  parameter int SPD_W       = 16,
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             hs_phase,
  input  logic [SPD_W-1:0] speed_khz,
  output logic             busy,
  output logic             cfg_ok,
  output logic             cfg_err,
  output logic [PSC_W-1:0] psc_o,
  output logic [CNT_W-1:0] scl_lo_o,
  output logic [CNT_W-1:0] scl_hi_o,
  output logic             scl_o
);
  localparam int HALF_W   = CNT_W / 2;
  localparam int DVS_W    = SPD_W + 1;
  localparam int PSC_STD  = FCLK_KHZ / STD_INT_KHZ - 1;
  localparam int PSC_FST  = FCLK_KHZ / FST_INT_KHZ - 1;
  localparam int PSC_HS   = FCLK_KHZ / HS_INT_KHZ - 1;
  localparam int PRE_BASE = HS_INT_KHZ / (2 * PRE_KHZ);

  // named internal events for the checker
  logic             go;
  logic             div_done;
  logic             wave_tick;
  logic             wave_flip;

  logic [1:0]       mode_q;
  logic             zero_q;
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] dividend;
  logic [DVS_W-1:0] divisor;

  assign go = start && !busy;

  always_comb begin
    case (mode)
      MODE_FAST: dividend = CNT_W'(FST_INT_KHZ);
      MODE_HS:   dividend = CNT_W'(HS_INT_KHZ);
      default:   dividend = CNT_W'(STD_INT_KHZ);
    endcase
    divisor = (mode == MODE_FAST) ? {1'b0, speed_khz} : {speed_khz, 1'b0};
  end

  scl_div #(.QW(CNT_W), .DW(DVS_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .dividend (dividend),
    .divisor  (divisor),
    .quotient (div_q),
    .done     (div_done)
  );

  // result arithmetic for the latched mode
  int               q_i, lo_i, hi_i, flo_i, fhi_i, psc_i;
  logic             bad_c;
  logic [CNT_W-1:0] lo_c, hi_c;

  always_comb begin
    q_i   = int'(div_q);
    lo_i  = 0;
    hi_i  = 0;
    flo_i = trim_sub(PRE_BASE, HS1_TRIM_LO);
    fhi_i = trim_sub(PRE_BASE, HS1_TRIM_HI);
    psc_i = PSC_STD;
    bad_c = 1'b0;
    lo_c  = '0;
    hi_c  = '0;
    case (mode_q)
      MODE_STD: begin
        lo_i  = trim_sub(q_i, TRIM_LO);
        hi_i  = trim_sub(q_i, TRIM_HI);
        bad_c = !fits_pos(lo_i, CNT_W) || !fits_pos(hi_i, CNT_W);
        lo_c  = CNT_W'(lo_i);
        hi_c  = CNT_W'(hi_i);
      end
      MODE_FAST: begin
        psc_i = PSC_FST;
        lo_i  = fast_low(q_i, TRIM_LO);
        hi_i  = fast_high(q_i, TRIM_HI);
        bad_c = !fits_pos(lo_i, CNT_W) || !fits_pos(hi_i, CNT_W);
        lo_c  = CNT_W'(lo_i);
        hi_c  = CNT_W'(hi_i);
      end
      MODE_HS: begin
        psc_i = PSC_HS;
        lo_i  = trim_sub(q_i, HS2_TRIM_LO);
        hi_i  = trim_sub(q_i, HS2_TRIM_HI);
        bad_c = !fits_nonneg(lo_i, HALF_W) || !fits_nonneg(hi_i, HALF_W) ||
                !fits_nonneg(flo_i, HALF_W) || !fits_nonneg(fhi_i, HALF_W);
        lo_c  = {HALF_W'(lo_i), HALF_W'(flo_i)};
        hi_c  = {HALF_W'(hi_i), HALF_W'(fhi_i)};
      end
      default: bad_c = 1'b1;
    endcase
    if (zero_q || !fits_pos(psc_i, PSC_W)) bad_c = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cfg_ok   <= 1'b0;
      cfg_err  <= 1'b0;
      mode_q   <= MODE_STD;
      zero_q   <= 1'b0;
      psc_o    <= '0;
      scl_lo_o <= '0;
      scl_hi_o <= '0;
    end else if (go) begin
      busy    <= 1'b1;
      cfg_ok  <= 1'b0;
      cfg_err <= 1'b0;
      mode_q  <= mode;
      zero_q  <= (speed_khz == '0);
    end else if (busy && div_done) begin
      busy     <= 1'b0;
      cfg_ok   <= !bad_c;
      cfg_err  <= bad_c;
      psc_o    <= bad_c ? '0 : PSC_W'(psc_i);
      scl_lo_o <= bad_c ? '0 : lo_c;
      scl_hi_o <= bad_c ? '0 : hi_c;
    end
  end

  // counts seen by the waveform generator
  logic [CNT_W-1:0] wave_lo, wave_hi;

  always_comb begin
    if (mode_q == MODE_HS) begin
      wave_lo = hs_phase ? CNT_W'(scl_lo_o[CNT_W-1:HALF_W]) : CNT_W'(scl_lo_o[HALF_W-1:0]);
      wave_hi = hs_phase ? CNT_W'(scl_hi_o[CNT_W-1:HALF_W]) : CNT_W'(scl_hi_o[HALF_W-1:0]);
    end else begin
      wave_lo = scl_lo_o;
      wave_hi = scl_hi_o;
    end
  end

  scl_wave #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_wave (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_ok),
    .psc    (psc_o),
    .lo_cnt (wave_lo),
    .hi_cnt (wave_hi),
    .scl    (scl_o),
    .tick_o (wave_tick),
    .flip_o (wave_flip)
  );
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             cfg_ok,
  input logic             cfg_err,
  input logic [PSC_W-1:0] psc_o,
  input logic [CNT_W-1:0] scl_lo_o,
  input logic [CNT_W-1:0] scl_hi_o,
  input logic             scl_o,
  input logic             div_done,
  input logic             wave_tick
);
  p_take_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !cfg_ok && !cfg_err);

  p_busy_until_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !div_done |=> busy);

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(psc_o) && $stable(scl_lo_o) && $stable(scl_hi_o));

  p_psc_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> psc_o != '0);

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_ok, cfg_err}));

  p_err_zeroed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (psc_o == '0) && (scl_lo_o == '0) && (scl_hi_o == '0));

  p_edge_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok && $past(cfg_ok) && !$stable(scl_o) |-> $past(wave_tick));

  p_idle_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> scl_o);
endmodule

bind scl_timing_gen scl_timing_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .cfg_ok    (cfg_ok),
  .cfg_err   (cfg_err),
  .psc_o     (psc_o),
  .scl_lo_o  (scl_lo_o),
  .scl_hi_o  (scl_hi_o),
  .scl_o     (scl_o),
  .div_done  (div_done),
  .wave_tick (wave_tick)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
  localparam int CLK_NS = 10;
  localparam int FCLK = 96000;
  localparam int INT_S = 4000, INT_F = 9600, INT_H = 19200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        hs_phase = 1'b0;
  logic [15:0] speed_khz = 16'd0;
  logic        busy, cfg_ok, cfg_err, scl_o;
  logic [7:0]  psc_o;
  logic [15:0] scl_lo_o, scl_hi_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS / 2) clk = ~clk;

  scl_timing_gen i_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .hs_phase(hs_phase),
    .speed_khz(speed_khz), .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err),
    .psc_o(psc_o), .scl_lo_o(scl_lo_o), .scl_hi_o(scl_hi_o), .scl_o(scl_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected results restated from the requirements
  task automatic expect_cfg(input int m, input int s, output int e_err,
                            output int e_psc, output int e_lo, output int e_hi);
    int q, t, a, b;
    e_err = 0; e_psc = 0; e_lo = 0; e_hi = 0;
    if (m == 3 || s == 0) begin
      e_err = 1;
    end else if (m == 0) begin
      q = INT_S / (2 * s);
      a = q - 7; b = q - 5;
      e_err = (a < 1 || b < 1 || a > 65535 || b > 65535) ? 1 : 0;
      e_psc = FCLK / INT_S - 1; e_lo = a; e_hi = b;
    end else if (m == 1) begin
      q = INT_F / s; t = q / 3;
      a = q - t - 7; b = t - 5;
      e_err = (a < 1 || b < 1 || a > 65535 || b > 65535) ? 1 : 0;
      e_psc = FCLK / INT_F - 1; e_lo = a; e_hi = b;
    end else begin
      q = INT_H / (2 * s);
      a = q - 7; b = q - 5;
      e_err = (a < 0 || b < 0 || a > 255 || b > 255) ? 1 : 0;
      e_psc = FCLK / INT_H - 1;
      e_lo = a * 256 + (INT_H / 800 - 7);
      e_hi = b * 256 + (INT_H / 800 - 5);
    end
    if (e_err == 1) begin e_psc = 0; e_lo = 0; e_hi = 0; end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 200) begin @(negedge clk); guard++; end
  endtask

  task automatic request(input int m, input int s);
    @(negedge clk);
    mode = 2'(m); speed_khz = 16'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_and_check(input string req, input int m, input int s);
    int e_err, e_psc, e_lo, e_hi;
    request(m, s);
    wait_idle();
    expect_cfg(m, s, e_err, e_psc, e_lo, e_hi);
    chk({req, " err"}, int'(cfg_err), e_err);
    chk({req, " ok"}, int'(cfg_ok), 1 - e_err);
    chk({req, " psc R3"}, int'(psc_o), e_psc);
    chk({req, " lo"}, int'(scl_lo_o), e_lo);
    chk({req, " hi"}, int'(scl_hi_o), e_hi);
  endtask

  task automatic measure(input string req, input int exp_lo, input int exp_hi);
    int lo_n = 0, hi_n = 0;
    while (scl_o !== 1'b1) @(negedge clk);
    while (scl_o !== 1'b0) @(negedge clk);
    while (scl_o === 1'b0) begin lo_n++; @(negedge clk); end
    while (scl_o === 1'b1) begin hi_n++; @(negedge clk); end
    chk({req, " low cycles"}, lo_n, exp_lo);
    chk({req, " high cycles"}, hi_n, exp_hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 ok", int'(cfg_ok), 0);
    chk("R1 err", int'(cfg_err), 0);
    chk("R1 psc", int'(psc_o), 0);
    chk("R1 lo", int'(scl_lo_o), 0);
    chk("R1 hi", int'(scl_hi_o), 0);
    chk("R1 scl", int'(scl_o), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 busy follows start
    request(0, 100);
    chk("R2 busy after start", int'(busy), 1);
    wait_idle();
    chk("R2 busy cleared", int'(busy), 0);

    // R4 standard sweep plus boundary
    for (int s = 1; s <= 320; s += 7) run_and_check("R4 std", 0, s);
    run_and_check("R8 std last valid", 0, 250);
    run_and_check("R8 std count zero", 0, 251);

    // R5 fast sweep plus boundary
    for (int s = 1; s <= 720; s += 11) run_and_check("R5 fast", 1, s);
    run_and_check("R8 fast last valid", 1, 533);
    run_and_check("R8 fast high zero", 1, 534);

    // R6 high-speed sweep, R7 range limits
    for (int s = 10; s <= 1600; s += 23) run_and_check("R6 hs", 2, s);
    run_and_check("R7 hs upper ok", 2, 37);
    run_and_check("R7 hs above 255", 2, 36);
    run_and_check("R7 hs zero ok", 2, 1371);
    run_and_check("R7 hs below 0", 2, 1372);

    // R9 invalid requests
    run_and_check("R9 std speed zero", 0, 0);
    run_and_check("R9 fast speed zero", 1, 0);
    run_and_check("R9 hs speed zero", 2, 0);
    run_and_check("R9 mode three", 3, 100);

    // R12 idle high after error
    begin
      int lows = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (scl_o !== 1'b1) lows++;
      end
      chk("R12 scl held high", lows, 0);
    end

    // R2 start ignored while busy
    request(1, 400);
    mode = 2'd3; speed_khz = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk("R2 second start ignored ok", int'(cfg_ok), 1);
    chk("R2 second start ignored lo", int'(scl_lo_o), 9);
    chk("R2 second start ignored hi", int'(scl_hi_o), 3);

    // R10 waveform lengths in fast mode: lo 9, hi 3, psc 9
    measure("R10 fast", 10 * 10, 4 * 10);

    // R10 standard: lo 13, hi 15, psc 23
    run_and_check("R10 std cfg", 0, 100);
    measure("R10 std", 14 * 24, 16 * 24);

    // R11 high-speed phase select: psc 4, preamble 17/19, hs 2/4
    hs_phase = 1'b0;
    run_and_check("R11 hs cfg", 2, 1000);
    measure("R11 preamble", 18 * 5, 20 * 5);
    @(negedge clk);
    hs_phase = 1'b1;
    measure("R11 hs phase", 3 * 5, 5 * 5);

    // R12 scl high while a new request is busy
    @(negedge clk);
    mode = 2'd0; speed_khz = 16'd50; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 scl high while busy", int'(scl_o), 1);
    wait_idle();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule